// File: doc/BRIEF.md
# Display-Enable Gap Frame Tracker

This block recovers picture timing from nothing but a display-enable signal. The enable comes from a source machine that runs at half the system clock rate, so it is sampled on the fast clock. The block watches how long the enable stays low. A quiet stretch longer than a fixed number of system clocks is taken as vertical blanking. The first enable assertion after such a stretch opens a new frame. Every other enable assertion opens a new active line. No vertical sync input is needed.

For each frame the block reports how many lines it held. It also reports the spacing, in system clocks, between successive line starts. An output video generator uses these figures to lock to the incoming picture. Frame length may change from one frame to the next; a 50 Hz source may alternate between 312 and 313 lines. Each frame's count is therefore reported on its own, and no length is assumed.

Top module: `dgf_frame_detect`

## Requirements
- R1: `de_in` passes through a two-stage synchroniser. A strobe caused by a rising enable appears on the third rising clock edge after `de_in` is first sampled high, and not on the second.
- R2: A rising enable opens a frame (`frame_start` pulses) only if the synchronised enable was low for more than `GAP_CLKS` consecutive clocks before it. A low run of exactly `GAP_CLKS` clocks does not open a frame.
- R3: The low-run counter saturates, so any low run longer than `GAP_CLKS` opens a frame, however long it lasts. The counter clears whenever the enable is high, so two short low runs separated by a high phase never add up.
- R4: Every rising enable that does not open a frame pulses `line_start`. Each strobe lasts exactly one clock cycle.
- R5: `line_idx` reads 0 after a frame start and rises by one at each line start.
- R6: `line_idx` saturates at 2^`LINE_W`-1. The reported line count saturates at the same value.
- R7: At each frame start that closes a complete frame, `frame_lines` takes the line count of that frame, counting its opening line. At that moment `frames_valid` goes high and stays high until reset. Between frame starts, `frame_lines` holds its value. Consecutive frames of 312 and 313 lines are each reported exactly.
- R8: At each line start, `line_clks` takes the number of clocks between this rising enable and the previous one, saturating at 2^`CLK_W`-1. A frame start leaves `line_clks` unchanged.
- R9: Reset clears every output to zero and clears the low-run counter. A rising enable that follows reset without a long low run is therefore counted as a line, not as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| de_in | input | 1 | Display enable from the source machine, asynchronous |
| frame_start | output | 1 | One-cycle strobe when a new frame begins |
| line_start | output | 1 | One-cycle strobe when a new active line begins within a frame |
| line_idx | output | LINE_W | Index of the current line; 0 is the line that opened the frame |
| frame_lines | output | LINE_W | Number of lines in the most recently completed frame |
| frames_valid | output | 1 | High once `frame_lines` holds a complete frame's count |
| line_clks | output | CLK_W | Clocks between the two most recent line-opening enable edges |

## Verification
The bench builds the block with `GAP_CLKS` set to 40, `LINE_W` set to 9 and `CLK_W` set to 8. The short gap threshold lets the bench test gaps exactly at the threshold, one clock over it, and far beyond it, all within a few hundred cycles. A 9-bit line index still holds 312 and 313, so alternating full-height frames are measured as they are. A 520-line frame then drives the index and the reported count into saturation. An 8-bit period field lets a single stretched enable pulse saturate the line-spacing measurement.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  // Event classification of one synchronised enable edge.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LINE  = 2'd1,
    EV_FRAME = 2'd2
  } dgf_event_e;
endpackage

// File: rtl/dgf_sync.sv
module dgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dgf_gap_timer.sv
module dgf_gap_timer #(
  parameter int GAP_CLKS = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic de_s,
  output logic de_rise,
  output logic gap_long
);
  localparam int GW = $clog2(GAP_CLKS + 2);
  localparam logic [GW-1:0] LIM_V = GW'(GAP_CLKS + 1);
  localparam logic [GW-1:0] THR_V = GW'(GAP_CLKS);

  logic          de_d;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_d  <= 1'b0;
      gap_q <= '0;
    end else begin
      de_d <= de_s;
      if (de_s)               gap_q <= '0;
      else if (gap_q != LIM_V) gap_q <= gap_q + 1'b1;
    end
  end

  assign de_rise  = de_s & ~de_d;
  assign gap_long = (gap_q > THR_V);

  // R3: a saturated counter stays saturated while the enable is low
  assert_gap_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (!de_s && gap_q == LIM_V) |=> (gap_q == LIM_V));
  // R3: any high enable clears the low-run count
  assert_gap_clear_R3: assert property (@(posedge clk) disable iff (rst)
    de_s |=> (gap_q == '0));
endmodule

// File: rtl/dgf_line_track.sv
module dgf_line_track
  import dgf_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int CLK_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  dgf_event_e        ev,
  output logic              frame_stb,
  output logic              line_stb,
  output logic [LINE_W-1:0] idx,
  output logic [LINE_W-1:0] lines,
  output logic              lines_vld,
  output logic [CLK_W-1:0]  period
);
  localparam logic [LINE_W-1:0] LMAX = '1;
  localparam logic [CLK_W-1:0]  CMAX = '1;

  function automatic logic [LINE_W-1:0] inc_line(input logic [LINE_W-1:0] v);
    return (v == LMAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CLK_W-1:0] inc_clk(input logic [CLK_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic             in_frame_q;
  logic [CLK_W-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_stb  <= 1'b0;
      line_stb   <= 1'b0;
      idx        <= '0;
      lines      <= '0;
      lines_vld  <= 1'b0;
      period     <= '0;
      in_frame_q <= 1'b0;
      since_q    <= '0;
    end else begin
      frame_stb <= (ev == EV_FRAME);
      line_stb  <= (ev == EV_LINE);
      if (ev == EV_NONE) since_q <= inc_clk(since_q);
      else               since_q <= '0;
      case (ev)
        EV_FRAME: begin
          idx        <= '0;
          in_frame_q <= 1'b1;
          if (in_frame_q) begin
            lines     <= inc_line(idx);
            lines_vld <= 1'b1;
          end
        end
        EV_LINE: begin
          idx    <= inc_line(idx);
          period <= inc_clk(since_q);
        end
        default: ;
      endcase
    end
  end

  // R4: strobes never repeat on consecutive cycles
  assert_frame_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> !frame_stb);
  assert_line_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !line_stb);
  // R7: valid flag never drops outside reset
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !$fell(lines_vld));
endmodule

// File: rtl/dgf_frame_detect.sv
module dgf_frame_detect
  import dgf_pkg::*;
#(
  parameter int GAP_CLKS = 2048,
  parameter int LINE_W   = 10,
  parameter int CLK_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de_in,
  output logic              frame_start,
  output logic              line_start,
  output logic [LINE_W-1:0] line_idx,
  output logic [LINE_W-1:0] frame_lines,
  output logic              frames_valid,
  output logic [CLK_W-1:0]  line_clks
);
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic       de_s;
  logic       de_rise;
  logic       gap_long;
  dgf_event_e ev;

  dgf_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .d_async(de_in), .d_sync(de_s)
  );

  dgf_gap_timer #(.GAP_CLKS(GAP_CLKS)) i_gap (
    .clk(clk), .rst(rst), .de_s(de_s), .de_rise(de_rise), .gap_long(gap_long)
  );

  always_comb begin
    if (!de_rise)      ev = EV_NONE;
    else if (gap_long) ev = EV_FRAME;
    else               ev = EV_LINE;
  end

  dgf_line_track #(.LINE_W(LINE_W), .CLK_W(CLK_W)) i_track (
    .clk(clk), .rst(rst), .ev(ev),
    .frame_stb(frame_start), .line_stb(line_start), .idx(line_idx),
    .lines(frame_lines), .lines_vld(frames_valid), .period(line_clks)
  );

  // R5: a frame start leaves the index at zero
  assert_idx_zero_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (line_idx == '0));
  // R5, R6: a line start advances the index by one or holds it at the ceiling
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (line_idx == $past(line_idx) + 1'b1 || line_idx == LMAX));
  // R7: line count changes only with a frame start
  assert_lines_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(frame_lines));
  // R8: line spacing changes only with a line start
  assert_period_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !line_start |-> $stable(line_clks));
endmodule

// File: tb/test_dgf_frame_detect.sv
module test_dgf_frame_detect;
  localparam int GAP = 40;
  localparam int LW  = 9;
  localparam int CW  = 8;
  localparam int NV  = 8;

  // {lo[15:0], hi[15:0], frame, line, idx[8:0]}
  localparam logic [42:0] VEC [NV] = '{
    {16'd50,  16'd6, 1'b1, 1'b0, 9'd0},  // R2 long gap opens frame
    {16'd5,   16'd6, 1'b0, 1'b1, 9'd1},  // R4 R5 line
    {16'd40,  16'd4, 1'b0, 1'b1, 9'd2},  // R2 exactly GAP is a line
    {16'd41,  16'd4, 1'b1, 1'b0, 9'd0},  // R2 GAP+1 opens frame
    {16'd20,  16'd3, 1'b0, 1'b1, 9'd1},  // R5
    {16'd30,  16'd3, 1'b0, 1'b1, 9'd2},  // R3 runs do not add up
    {16'd200, 16'd5, 1'b1, 1'b0, 9'd0},  // R3 saturated long gap
    {16'd1,   16'd5, 1'b0, 1'b1, 9'd1}   // R4 minimal gap
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          de_in = 1'b0;
  logic          frame_start, line_start, frames_valid;
  logic [LW-1:0] line_idx, frame_lines;
  logic [CW-1:0] line_clks;

  int checks = 0;
  int errors = 0;
  logic          s_fs, s_ls, s_vld;
  logic [LW-1:0] s_idx, s_lines;
  logic [CW-1:0] s_per;

  always #4 clk = ~clk;

  dgf_frame_detect #(.GAP_CLKS(GAP), .LINE_W(LW), .CLK_W(CW)) i_dgf_frame_detect (
    .clk(clk), .rst(rst), .de_in(de_in),
    .frame_start(frame_start), .line_start(line_start), .line_idx(line_idx),
    .frame_lines(frame_lines), .frames_valid(frames_valid), .line_clks(line_clks)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Low for lo cycles, then high for hi cycles (hi >= 3); samples outputs
  // in the cycle after the third edge that sees the enable high.
  task automatic pulse(input int lo, input int hi);
    de_in = 1'b0;
    repeat (lo) @(negedge clk);
    de_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    s_fs = frame_start; s_ls = line_start; s_idx = line_idx;
    s_lines = frame_lines; s_vld = frames_valid; s_per = line_clks;
    repeat (hi - 3) @(negedge clk);
  endtask

  task automatic frame(input int n);
    pulse(50, 4);
    for (int i = 1; i < n; i++) pulse(2, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 frame_start", frame_start, 0);
    check("R9 line_start", line_start, 0);
    check("R9 line_idx", line_idx, 0);
    check("R9 frame_lines", frame_lines, 0);
    check("R9 valid", frames_valid, 0);
    check("R9 line_clks", line_clks, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      pulse(int'(VEC[v][42:27]), int'(VEC[v][26:11]));
      check($sformatf("R2 R3 R4 frame vec%0d", v), s_fs, int'(VEC[v][10]));
      check($sformatf("R4 line vec%0d", v), s_ls, int'(VEC[v][9]));
      check($sformatf("R5 idx vec%0d", v), s_idx, int'(VEC[v][8:0]));
      if (v == 0) check("R7 no valid after first frame", s_vld, 0);
    end
    check("R7 lines of 3-line frame", frame_lines, 3);
    check("R7 valid set", frames_valid, 1);
    check("R8 line period", line_clks, 6);

    // R1 latency
    de_in = 1'b0;
    repeat (60) @(negedge clk);
    de_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 no strobe at edge 2", frame_start, 0);
    @(negedge clk);
    check("R1 strobe at edge 3", frame_start, 1);
    @(negedge clk);
    check("R4 strobe one cycle", frame_start, 0);
    repeat (3) @(negedge clk);

    // R7 alternating 312/313
    frame(312);
    frame(313);
    check("R7 lines 312", s_lines, 312);
    check("R5 idx end of 313 frame", line_idx, 312);
    check("R8 period in frame", line_clks, 6);
    frame(312);
    check("R7 lines 313", s_lines, 313);
    frame(5);
    check("R7 lines 312 again", s_lines, 312);
    check("R7 valid held", s_vld, 1);

    // R6 saturation
    frame(520);
    check("R6 idx saturated", line_idx, 511);
    pulse(50, 4);
    check("R6 lines saturated", s_lines, 511);

    // R8 period saturation, and frame start leaves it
    pulse(5, 300);
    pulse(5, 4);
    check("R8 period saturated", s_per, 255);
    pulse(5, 4);
    check("R8 period 9", s_per, 9);
    pulse(50, 4);
    check("R8 frame keeps period", s_per, 9);

    // R9 mid-run reset, then a short gap is only a line
    de_in = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 lines cleared", frame_lines, 0);
    check("R9 valid cleared", frames_valid, 0);
    rst = 1'b0;
    pulse(5, 4);
    check("R9 no frame after reset", s_fs, 0);
    check("R9 line after reset", s_ls, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule